// File: doc/BRIEF.md
# Self-Clocked ADC Serial Result Receiver

This block sits on the host side of a sampling converter that drives its own data clock while it converts. On a start request the host asserts the combined convert condition: the convert strobe and the device select are pulled low together for a fixed number of host cycles. The converter then lowers BUSY, emits sixteen clock pulses with one data bit on each, and raises BUSY when the conversion finishes.

The device clock, the data line and BUSY reach the host clock domain through two-flop synchronizers. Rising edges of the device clock are found by comparing consecutive synchronized samples. Bits are taken only while the synchronized BUSY is low. The rising edge of BUSY closes the frame. A complete frame is presented as a 16-bit word with a one-cycle valid strobe. The word shifted out during a conversion is the result of the conversion before it, so each word carries a flag that says whether such an earlier conversion exists. A frame that ends early is dropped and reported.

The host clock must run at least ten times faster than the device clock, and never slower than 10 MHz.

Top module: `adc_selfclk_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, conv_n_o and cs_n_o are 1, word_vld_o, word_prior_ok_o and frame_err_o are 0, and word_o is 0.
- R2: A start_i seen in the idle state drives conv_n_o and cs_n_o low together in the next cycle. They stay low for exactly CNV_LOW_CYC host cycles and then both return high.
- R3: start_i is ignored from the moment a strobe begins until the synchronized BUSY has gone low and then high again. No second strobe is issued in that span.
- R4: While synchronized BUSY is low, each rising edge of the synchronized device clock shifts in the synchronized data bit. The first bit lands in word bit 15, so the first bit received is the MSB.
- R5: When BUSY rises after exactly 16 captured bits, word_vld_o pulses high for one cycle and word_o shows the captured word. The pulse comes three host cycles after the cycle in which BUSY_i is first sampled high, and word_o holds its value until the next good frame.
- R6: word_prior_ok_o is updated together with word_o. It is 0 for the first conversion that completes after reset and 1 for every later one.
- R7: Device clock edges while BUSY is high do not change the captured word.
- R8: If BUSY rises with fewer than 16 bits captured, frame_err_o pulses for one cycle, word_vld_o stays low and word_o keeps its old value.
- R9: Device clock edges after the 16th within one BUSY-low window are ignored. The word holds the first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| busy_i | input | 1 | Converter BUSY, low while converting (asynchronous) |
| dclk_i | input | 1 | Converter-driven data clock (asynchronous) |
| sdata_i | input | 1 | Converter serial data (asynchronous) |
| conv_n_o | output | 1 | Convert strobe, active low |
| cs_n_o | output | 1 | Device select, active low |
| word_o | output | 16 | Last complete received word |
| word_vld_o | output | 1 | One-cycle pulse when word_o is updated |
| word_prior_ok_o | output | 1 | Word belongs to a real earlier conversion |
| frame_err_o | output | 1 | One-cycle pulse on a short frame |

## Verification
The hardest cases to reach are the ones where the device clock and BUSY are out of their usual order. These are clock pulses before BUSY falls, extra pulses past the sixteenth, and BUSY rising early. A normal converter never produces them. The bench therefore plays the converter itself, with a frame task that can add pulses while BUSY is still high, append surplus pulses, or cut the bit count short. Start requests are also injected in the middle of a frame, to show they are ignored. A behavioural model that tracks the three-cycle input latency is compared with the outputs on every clock.

// File: rtl/adc_rx_pkg.sv
// Shared types for the self-clocked ADC receiver.
package adc_rx_pkg;
    // Phases of the convert-strobe sequencer.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_WAIT_LO = 2'd2,
        ST_WAIT_HI = 2'd3
    } strobe_st_e;
endpackage

// File: rtl/adc_rx_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is independent; no bus coherence is given.
module adc_rx_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1, s2;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[g];
                    s2 <= RST_VAL[g];
                end else begin
                    s1 <= d_i[g];
                    s2 <= s1;
                end
            end
            assign q_o[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/adc_rx_strobe.sv
// Convert-strobe sequencer. On start in idle, pulls convert and select
// low together for CNV_LOW_CYC cycles, then waits for one full BUSY
// low/high cycle before accepting another start.
// Assumes busy_s is already synchronized to clk.
module adc_rx_strobe
    import adc_rx_pkg::*;
#(
    parameter int CNV_LOW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_s,
    output logic conv_n_o,
    output logic cs_n_o
);
    localparam int PW = (CNV_LOW_CYC > 1) ? $clog2(CNV_LOW_CYC) : 1;
    localparam logic [PW-1:0] PLAST = PW'(CNV_LOW_CYC - 1);

    strobe_st_e    state;
    logic [PW-1:0] pcnt;

    // Sequencer: pulse timing and wait for the device to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pcnt     <= '0;
            conv_n_o <= 1'b1;
            cs_n_o   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    state    <= ST_PULSE;
                    pcnt     <= '0;
                    conv_n_o <= 1'b0;
                    cs_n_o   <= 1'b0;
                end
                ST_PULSE: if (pcnt == PLAST) begin
                    state    <= ST_WAIT_LO;
                    conv_n_o <= 1'b1;
                    cs_n_o   <= 1'b1;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
                ST_WAIT_LO: if (!busy_s) state <= ST_WAIT_HI;
                ST_WAIT_HI: if (busy_s) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: outside idle the strobe never starts a new pulse.
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !$fell(conv_n_o));
    // R2: the strobe is released only at the end of the pulse phase.
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n_o) |-> (state == ST_WAIT_LO));
    // R2: convert and select move as a pair.
    a_r2_pair: assert property (@(posedge clk) disable iff (!rst_n)
        conv_n_o == cs_n_o);
endmodule

// File: rtl/adc_rx_shift.sv
// Frame capture. Finds rising edges of the synchronized device clock,
// shifts bits in MSB first while BUSY is low, and closes the frame on
// the BUSY rising edge: a full frame gives a word, a short one an error.
// Assumes all inputs come from adc_rx_sync.
module adc_rx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_s,
    input  logic              dclk_s,
    input  logic              sdata_s,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              word_prior_ok_o,
    output logic              frame_err_o
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);

    logic              busy_d, dclk_d, seen;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] shreg;
    logic              busy_rise, dclk_rise;

    assign busy_rise = busy_s & ~busy_d;
    assign dclk_rise = dclk_s & ~dclk_d;

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d <= 1'b1;
            dclk_d <= 1'b0;
        end else begin
            busy_d <= busy_s;
            dclk_d <= dclk_s;
        end
    end

    // Bit capture, frame closing and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt             <= '0;
            shreg           <= '0;
            seen            <= 1'b0;
            word_o          <= '0;
            word_vld_o      <= 1'b0;
            word_prior_ok_o <= 1'b0;
            frame_err_o     <= 1'b0;
        end else begin
            word_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
            if (busy_rise) begin
                if (cnt == FULL) begin
                    word_o          <= shreg;
                    word_vld_o      <= 1'b1;
                    word_prior_ok_o <= seen;
                end else begin
                    frame_err_o <= 1'b1;
                end
                seen <= 1'b1;
                cnt  <= '0;
            end else if (!busy_s && dclk_rise && cnt != FULL) begin
                shreg <= {shreg[WORD_W-2:0], sdata_s};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // R4: the bit counter never passes the word width.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    // R5: the valid strobe lasts one cycle.
    a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);
    // R9: a full shift register is frozen for the rest of the window.
    a_r9_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && !busy_s) |=> $stable(shreg));
    // R8: an error report leaves the published word alone.
    a_r8_err_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> $stable(word_o));
    // R7: with BUSY high and no frame end, captured bits do not move.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_s && busy_d) |=> $stable(shreg));
endmodule

// File: rtl/adc_selfclk_rx.sv
// Top of the self-clocked ADC receiver: synchronizers, strobe
// sequencer and frame capture. Assumes clk runs at least ten times
// faster than the device data clock and no slower than 10 MHz.
module adc_selfclk_rx #(
    parameter int WORD_W      = 16,
    parameter int CNV_LOW_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              dclk_i,
    input  logic              sdata_i,
    output logic              conv_n_o,
    output logic              cs_n_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              word_prior_ok_o,
    output logic              frame_err_o
);
    logic [2:0] sync_q;

    adc_rx_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({busy_i, dclk_i, sdata_i}),
        .q_o   (sync_q)
    );

    adc_rx_strobe #(.CNV_LOW_CYC(CNV_LOW_CYC)) i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .busy_s   (sync_q[2]),
        .conv_n_o (conv_n_o),
        .cs_n_o   (cs_n_o)
    );

    adc_rx_shift #(.WORD_W(WORD_W)) i_shift (
        .clk             (clk),
        .rst_n           (rst_n),
        .busy_s          (sync_q[2]),
        .dclk_s          (sync_q[1]),
        .sdata_s         (sync_q[0]),
        .word_o          (word_o),
        .word_vld_o      (word_vld_o),
        .word_prior_ok_o (word_prior_ok_o),
        .frame_err_o     (frame_err_o)
    );
endmodule

// File: tb/test_adc_selfclk_rx.sv
module test_adc_selfclk_rx;
    localparam int CLK_PERIOD = 10;
    localparam int LOWC = 4;
    localparam int HALF = 6;
    localparam int WD_CYC = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, busy_i = 1, dclk_i = 0, sdata_i = 0;
    logic conv_n_o, cs_n_o, word_vld_o, word_prior_ok_o, frame_err_o;
    logic [15:0] word_o;

    int tests = 0, fails = 0;

    adc_selfclk_rx #(.WORD_W(16), .CNV_LOW_CYC(LOWC)) i_adc_selfclk_rx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
        .dclk_i(dclk_i), .sdata_i(sdata_i), .conv_n_o(conv_n_o),
        .cs_n_o(cs_n_o), .word_o(word_o), .word_vld_o(word_vld_o),
        .word_prior_ok_o(word_prior_ok_o), .frame_err_o(frame_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model, state as seen after each posedge.
    bit hb[$], hc[$], hd[$];
    int m_st = 0, m_pc = 0, m_cnt = 0;
    bit m_conv = 1, m_seen = 0, m_vld = 0, m_err = 0, m_ok = 0, pb = 1, pc = 0;
    logic [15:0] m_sh = 0, m_word = 0;
    // Scenario observations.
    int n_vld = 0, n_err = 0, n_fall = 0;
    bit last_ok = 0, conv_prev = 1;
    logic [15:0] last_word = 0;

    initial begin
        repeat (3) begin hb.push_back(1); hc.push_back(0); hd.push_back(0); end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit b, c, d, br, cr;
            hb.push_back(busy_i); hc.push_back(dclk_i); hd.push_back(sdata_i);
            b = hb[hb.size()-3]; c = hc[hc.size()-3]; d = hd[hd.size()-3];
            void'(hb.pop_front()); void'(hc.pop_front()); void'(hd.pop_front());
            br = b & ~pb; cr = c & ~pc;
            m_vld = 0; m_err = 0;
            if (br) begin
                if (m_cnt == 16) begin m_word = m_sh; m_vld = 1; m_ok = m_seen; end
                else m_err = 1;
                m_seen = 1; m_cnt = 0;
            end else if (!b && cr && m_cnt < 16) begin
                m_sh = {m_sh[14:0], d}; m_cnt++;
            end
            pb = b; pc = c;
            case (m_st)
                0: if (start_i) begin m_st = 1; m_pc = 0; m_conv = 0; end
                1: if (m_pc == LOWC-1) begin m_st = 2; m_conv = 1; end else m_pc++;
                2: if (!b) m_st = 3;
                default: if (b) m_st = 0;
            endcase
            check("R2/R3 conv_n", {31'd0, conv_n_o}, {31'd0, m_conv});
            check("R2 cs_n", {31'd0, cs_n_o}, {31'd0, m_conv});
            check("R5 word_vld", {31'd0, word_vld_o}, {31'd0, m_vld});
            check("R8 frame_err", {31'd0, frame_err_o}, {31'd0, m_err});
            check("R4 word", {16'd0, word_o}, {16'd0, m_word});
            check("R6 prior_ok", {31'd0, word_prior_ok_o}, {31'd0, m_ok});
            if (word_vld_o) begin n_vld++; last_word = word_o; last_ok = word_prior_ok_o; end
            if (frame_err_o) n_err++;
            if (conv_prev && !conv_n_o) n_fall++;
            conv_prev = conv_n_o;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic host_start();
        tick(1); start_i = 1; tick(1); start_i = 0;
    endtask

    // Plays the converter for one frame.
    task automatic device_frame(input logic [15:0] w, input int nbits,
                                input int extra, input int pre);
        do @(negedge clk); while (conv_n_o);
        #1;
        for (int i = 0; i < pre; i++) begin
            tick(HALF); dclk_i = 1; tick(HALF); dclk_i = 0;
        end
        tick(8); busy_i = 0; tick(2);
        for (int i = 0; i < nbits + extra; i++) begin
            sdata_i = (i < 16) ? w[15-i] : ~w[15 - (i % 16)];
            tick(HALF); dclk_i = 1; tick(HALF); dclk_i = 0;
        end
        tick(4); busy_i = 1; tick(30);
    endtask

    task automatic frame(input logic [15:0] w, input int nbits,
                         input int extra, input int pre, input bit poke);
        fork
            device_frame(w, nbits, extra, pre);
            host_start();
            if (poke) begin tick(40); start_i = 1; tick(3); start_i = 0;
                            tick(60); start_i = 1; tick(1); start_i = 0; end
        join
    endtask

    task automatic run_all();
        int v0, e0, f0;
        tick(3);
        check("R1 conv_n reset", {31'd0, conv_n_o}, 32'd1);
        check("R1 cs_n reset", {31'd0, cs_n_o}, 32'd1);
        check("R1 vld/err reset", {30'd0, word_vld_o, frame_err_o}, 32'd0);
        check("R1 word reset", {15'd0, word_prior_ok_o, word_o}, 32'd0);
        rst_n = 1;
        tick(1);
        check("R1 first cycle", {14'd0, conv_n_o, cs_n_o, word_o}, 32'h30000);

        frame(16'hA5C3, 16, 0, 0, 0);
        check("R4 first word", {16'd0, last_word}, 32'hA5C3);
        check("R6 first not prior", {31'd0, last_ok}, 32'd0);

        f0 = n_fall;
        frame(16'h3C96, 16, 0, 0, 1);
        check("R3 one strobe per frame", n_fall - f0, 1);
        check("R6 later prior ok", {31'd0, last_ok}, 32'd1);
        check("R4 second word", {16'd0, last_word}, 32'h3C96);

        frame(16'h8001, 16, 0, 3, 0);
        check("R7 pre-clock ignored", {16'd0, last_word}, 32'h8001);

        frame(16'h7FFE, 16, 3, 0, 0);
        check("R9 extra clocks ignored", {16'd0, last_word}, 32'h7FFE);

        v0 = n_vld; e0 = n_err;
        frame(16'h1234, 10, 0, 0, 0);
        check("R8 short frame error", n_err - e0, 1);
        check("R8 short frame no vld", n_vld - v0, 0);
        check("R8 word kept", {16'd0, word_o}, 32'h7FFE);

        v0 = n_vld;
        frame(16'hFFFF, 16, 0, 0, 0);
        check("R5 one pulse", n_vld - v0, 1);
        check("R4 all ones", {16'd0, last_word}, 32'hFFFF);
        frame(16'h0000, 16, 0, 0, 0);
        check("R4 all zeros", {16'd0, word_o}, 32'h0000);
        check("R6 prior after error", {31'd0, last_ok}, 32'd1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD_CYC) @(posedge clk);
                tests++; fails++;
                $display("FAIL R4 watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule